// File: doc/BRIEF.md
# Backplane Memory Slave with Boot Overlay

This block is a memory card for an 8-bit parallel backplane. It holds a 1 KB primary RAM and a 256-byte boot ROM, and it answers memory cycles from the current bus master. A level on the shared memory-expansion line decides which of the two stores responds. When the line is low, the RAM is selected. When the line is high, the RAM is switched out and the boot ROM occupies the bottom of the address space.

The card also drives that line. A one-bit overlay flag is set by reset, so the card holds the line high and the processor starts from the boot ROM. Boot code then writes to one I/O port, which clears the flag, releases the line and hands the address space back to RAM. Bus inputs are sampled on the card clock. Read data and its output enable come one cycle after the qualified read cycle.

Top module: `memslv_top`

## Requirements
- R1: A memory operation is recognised only in a cycle where `memrq_n` is low and either `rd_n` or `wr_n` is low. In any other cycle the RAM is not written and `data_oe` is low in the following cycle.
- R2: A recognised read of a selected location raises `data_oe` and presents the addressed byte on `data_out` in the cycle after the read cycle. Whenever `data_oe` is low, `data_out` is 0.
- R3: The RAM is selected only while `memex_in` is low. Its 1024 bytes are indexed by `addr[9:0]`.
- R4: A recognised write while the RAM is selected stores `data_in` at the addressed RAM byte, and a later read returns that byte.
- R5: While `memex_in` is high, addresses 0x0000 to 0x00FF read the boot ROM. The byte at offset i is (i*37 + 0x5A) mod 256.
- R6: While `memex_in` is high, a memory read at address 0x0100 or above gets no response, so `data_oe` stays low.
- R7: Writes while `memex_in` is high change no RAM contents.
- R8: After reset the overlay flag is set, and `memex_drive` is high.
- R9: An I/O write (`iorq_n` and `wr_n` low) with `addr[7:0]` equal to 0xF0 clears the flag, and `memex_drive` goes low in the next cycle. I/O writes to other ports have no effect. Once cleared, the flag sets again only on reset.
- R10: With the default `MIRROR`=1, addresses at 0x0400 and above alias to RAM through `addr[9:0]`. With `MIRROR`=0 those addresses get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 16 | Bus address |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data to the bus |
| data_oe | output | 1 | Read data drive enable |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| memrq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| memex_in | input | 1 | Memory-expansion line level seen on the bus |
| memex_drive | output | 1 | Drive the memory-expansion line high (overlay active) |

## Verification
The overlay flag is the only long-lived control state. If it is wrong, `memex_drive` shows it at once: the flag is high from reset and must fall exactly one cycle after a write to port 0xF0. Any later rise points to a fault. A wrong selection decode shows on the next cycle, either as a `data_oe` pulse for an address that should not answer or as the wrong source byte for a ROM or RAM address. Writes that are lost or should have been blocked do not show until that location is read again. The bench therefore reads back every location it writes, and it rereads a RAM byte after a write attempt made while the ROM was selected.

// File: rtl/memslv_pkg.sv
package memslv_pkg;

    localparam int DATA_W = 8;

    // Registered card state: read return path and overlay flag
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              oe;
        logic              overlay;
    } memslv_state_t;

    // Boot ROM content, computed rather than tabulated
    function automatic logic [DATA_W-1:0] boot_byte(input logic [15:0] idx);
        logic [15:0] acc;
        acc = idx * 16'd37 + 16'h005A;
        return acc[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/memslv_decode.sv
module memslv_decode #(
    parameter int ADDR_W    = 16,
    parameter int RAM_AW    = 10,
    parameter int ROM_AW    = 8,
    parameter bit MIRROR    = 1'b1,
    parameter int PORT_W    = 8,
    parameter logic [PORT_W-1:0] CTRL_PORT = 8'hF0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              memrq_n,
    input  logic              iorq_n,
    input  logic              memex_in,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic              rom_rd,
    output logic              ctrl_wr,
    output logic [RAM_AW-1:0] ram_idx,
    output logic [ROM_AW-1:0] rom_idx
);
    localparam int HI_RAM = ADDR_W - RAM_AW;
    localparam int HI_ROM = ADDR_W - ROM_AW;

    logic mem_rd, mem_wr;
    logic ram_range, rom_range;

    assign mem_rd = !memrq_n && !rd_n;
    assign mem_wr = !memrq_n && !wr_n;

    generate
        if (MIRROR) begin : g_mirror
            assign ram_range = 1'b1;
        end else begin : g_exact
            assign ram_range = (addr[ADDR_W-1:RAM_AW] == {HI_RAM{1'b0}});
        end
    endgenerate

    assign rom_range = (addr[ADDR_W-1:ROM_AW] == {HI_ROM{1'b0}});

    assign ram_idx = addr[RAM_AW-1:0];
    assign rom_idx = addr[ROM_AW-1:0];

    always_comb begin
        ram_rd  = mem_rd && !memex_in && ram_range;
        ram_wr  = mem_wr && !mem_rd && !memex_in && ram_range;
        rom_rd  = mem_rd && memex_in && rom_range;
        ctrl_wr = !iorq_n && !wr_n && (addr[PORT_W-1:0] == CTRL_PORT);
    end
endmodule

// File: rtl/memslv_ram.sv
module memslv_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/memslv_bootrom.sv
module memslv_bootrom
    import memslv_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0]     idx,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = boot_byte(16'(idx));
    end
endmodule

// File: rtl/memslv_top.sv
module memslv_top
    import memslv_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RAM_AW = 10,
    parameter int ROM_AW = 8,
    parameter bit MIRROR = 1'b1,
    parameter logic [7:0] CTRL_PORT = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              memrq_n,
    input  logic              iorq_n,
    input  logic              memex_in,
    output logic              memex_drive
);
    logic              ram_rd, ram_wr, rom_rd, ctrl_wr;
    logic [RAM_AW-1:0] ram_idx;
    logic [ROM_AW-1:0] rom_idx;
    logic [DATA_W-1:0] ram_rdata, rom_rdata;

    memslv_state_t st_d, st_q;

    memslv_decode #(
        .ADDR_W    (ADDR_W),
        .RAM_AW    (RAM_AW),
        .ROM_AW    (ROM_AW),
        .MIRROR    (MIRROR),
        .PORT_W    (8),
        .CTRL_PORT (CTRL_PORT)
    ) u_dec (
        .addr     (addr),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .memrq_n  (memrq_n),
        .iorq_n   (iorq_n),
        .memex_in (memex_in),
        .ram_rd   (ram_rd),
        .ram_wr   (ram_wr),
        .rom_rd   (rom_rd),
        .ctrl_wr  (ctrl_wr),
        .ram_idx  (ram_idx),
        .rom_idx  (rom_idx)
    );

    memslv_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_wr),
        .idx   (ram_idx),
        .wdata (data_in),
        .rdata (ram_rdata)
    );

    memslv_bootrom #(.AW(ROM_AW)) u_rom (
        .idx   (rom_idx),
        .rdata (rom_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.oe    = 1'b0;
        st_d.rdata = '0;
        if (ram_rd) begin
            st_d.oe    = 1'b1;
            st_d.rdata = ram_rdata;
        end else if (rom_rd) begin
            st_d.oe    = 1'b1;
            st_d.rdata = rom_rdata;
        end
        if (ctrl_wr) begin
            st_d.overlay = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rdata   <= '0;
            st_q.oe      <= 1'b0;
            st_q.overlay <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out    = st_q.rdata;
    assign data_oe     = st_q.oe;
    assign memex_drive = st_q.overlay;
endmodule

// File: rtl/memslv_chk.sv
module memslv_chk #(
    parameter int ADDR_W = 16,
    parameter int RAM_AW = 10,
    parameter int ROM_AW = 8,
    parameter bit MIRROR = 1'b1,
    parameter logic [7:0] CTRL_PORT = 8'hF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_n,
    input logic              wr_n,
    input logic              memrq_n,
    input logic              iorq_n,
    input logic              memex_in,
    input logic              data_oe,
    input logic [7:0]        data_out,
    input logic              memex_drive
);
    localparam int RAM_SIZE = 1 << RAM_AW;
    localparam int ROM_SIZE = 1 << ROM_AW;

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (memrq_n || rd_n) |=> !data_oe);

    assert_read_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!memrq_n && !rd_n && !memex_in && (MIRROR || int'(addr) < RAM_SIZE)) |=> data_oe);

    assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == 8'h00));

    assert_rom_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!memrq_n && memex_in && int'(addr) >= ROM_SIZE) |=> !data_oe);

    assert_boot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> memex_drive);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && !wr_n && addr[7:0] == CTRL_PORT) |=> !memex_drive);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !memex_drive |=> !memex_drive);
endmodule

bind memslv_top memslv_chk #(
    .ADDR_W    (ADDR_W),
    .RAM_AW    (RAM_AW),
    .ROM_AW    (ROM_AW),
    .MIRROR    (MIRROR),
    .CTRL_PORT (CTRL_PORT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .memrq_n     (memrq_n),
    .iorq_n      (iorq_n),
    .memex_in    (memex_in),
    .data_oe     (data_oe),
    .data_out    (data_out),
    .memex_drive (memex_drive)
);

// File: tb/tb_memslv_top.sv
module tb_memslv_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        rd_n = 1'b1, wr_n = 1'b1, memrq_n = 1'b1, iorq_n = 1'b1;
    logic        force_hi = 1'b0;
    logic        memex_drive;
    logic        memex_in;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int       due;
        bit       oe;
        bit [7:0] data;
        string    req;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Wired-OR view of the shared expansion line
    assign memex_in = memex_drive | force_hi;

    memslv_top dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .rd_n(rd_n), .wr_n(wr_n),
        .memrq_n(memrq_n), .iorq_n(iorq_n), .memex_in(memex_in),
        .memex_drive(memex_drive)
    );

    function automatic bit [7:0] rom_val(int i);
        return 8'((i * 37 + 90) % 256);
    endfunction

    // Monitor: compare queued expectations in their due cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (data_oe !== it.oe || (it.oe && data_out !== it.data)) begin
                n_bad++;
                $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
                         it.req, data_oe, data_out, it.oe, it.data);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1; memrq_n = 1'b1; iorq_n = 1'b1;
    endtask

    task automatic mem_rd(input bit [15:0] a, input bit oe, input bit [7:0] d, input string req);
        item_t it;
        @(negedge clk);
        addr = a; rd_n = 1'b0; wr_n = 1'b1; memrq_n = 1'b0; iorq_n = 1'b1;
        it.due = cyc + 1; it.oe = oe; it.data = d; it.req = req;
        sb.push_back(it);
    endtask

    task automatic mem_wr(input bit [15:0] a, input bit [7:0] d);
        @(negedge clk);
        addr = a; data_in = d; rd_n = 1'b1; wr_n = 1'b0; memrq_n = 1'b0; iorq_n = 1'b1;
    endtask

    task automatic io_wr(input bit [7:0] port);
        @(negedge clk);
        addr = {8'h00, port}; data_in = 8'h00; rd_n = 1'b1; wr_n = 1'b0;
        memrq_n = 1'b1; iorq_n = 1'b0;
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit(memex_drive, 1'b1, "R8 boot overlay after reset");
        chk_bit(data_oe, 1'b0, "R2 oe low after reset");

        // R5 boot ROM reads at both ends and middle
        mem_rd(16'h0000, 1, rom_val(0), "R5 rom 0000");
        mem_rd(16'h0011, 1, rom_val(17), "R5 rom 0011");
        mem_rd(16'h00FF, 1, rom_val(255), "R5 rom 00FF");
        // R6 no response above ROM while line high
        mem_rd(16'h0100, 0, 8'h00, "R6 rom gap 0100");
        mem_rd(16'h8000, 0, 8'h00, "R6 rom gap 8000");
        // R9 other port has no effect
        io_wr(8'hF1);
        idle();
        chk_bit(memex_drive, 1'b1, "R9 other port ignored");
        // R9 control port clears overlay
        io_wr(8'hF0);
        idle();
        chk_bit(memex_drive, 1'b0, "R9 control port clears");

        // R4 RAM write and readback
        mem_wr(16'h0000, 8'h11);
        mem_wr(16'h0010, 8'h22);
        mem_wr(16'h03FF, 8'h33);
        mem_wr(16'h0020, 8'h44);
        mem_rd(16'h0000, 1, 8'h11, "R4 ram 0000");
        mem_rd(16'h0010, 1, 8'h22, "R4 ram 0010");
        mem_rd(16'h03FF, 1, 8'h33, "R4 ram 03FF");

        // R7 write while ROM selected is dropped; R3 ROM serves when line high
        idle();
        force_hi = 1'b1;
        mem_wr(16'h0020, 8'h99);
        mem_rd(16'h0020, 1, rom_val(32), "R3 ram deselected, rom 0020");
        idle();
        force_hi = 1'b0;
        mem_rd(16'h0020, 1, 8'h44, "R7 ram kept during rom write");

        // R10 mirroring
        mem_rd(16'h0410, 1, 8'h22, "R10 alias 0410");
        mem_wr(16'h8400, 8'h55);
        mem_rd(16'h0000, 1, 8'h55, "R10 alias write 8400");

        // R1 unqualified cycles
        @(negedge clk);
        addr = 16'h0010; rd_n = 1'b0; memrq_n = 1'b1; iorq_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        chk_bit(data_oe, 1'b0, "R1 read without memrq");
        addr = 16'h0010; data_in = 8'hAA; wr_n = 1'b0; rd_n = 1'b1; memrq_n = 1'b1; iorq_n = 1'b0;
        mem_rd(16'h0010, 1, 8'h22, "R1 io write left ram");
        idle();
        @(negedge clk);
        chk_bit(data_oe, 1'b0, "R2 oe drops after read");
        chk_bit(memex_drive, 1'b0, "R9 flag stays clear");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        finish_run();
    end
endmodule